// File: doc/BRIEF.md
# Dual-Port GPIO with Edge Interrupts

This peripheral drives two 8-bit banks of general-purpose pins through one 32-byte window on a byte-wide register bus. The even byte of each register pair belongs to bank A and the odd byte to bank B. Every pin can be a plain input, a plain output, or it can hand its pad to one of three alternate functions that other modules supply. A pull resistor can be switched on per pin, and its direction comes from that pin's output data bit.

Pin levels pass through a synchronizer. The synchronized levels feed a readable level register and a per-pin edge detector. Each detected edge sets a sticky flag. Flags that are enabled drive one interrupt line per bank. Each bank also has a vector register: reading it returns a code for the lowest pending pin and retires that one flag, so firmware can service pins one at a time.

Top module: `dual_gpio_port`

## Requirements
- R1: After reset every configuration and flag register reads 0, and all of `pad_oe`, `pad_pull_en`, `pad_pull_up`, `pad_drive` and `irq` are 0.
- R2: The level register (0x00 for bank A, 0x01 for bank B) returns the pad levels two clock edges after they change. Writes to it have no effect.
- R3: With function code {SEL1,SEL0} = 00, `pad_oe` equals the direction bit (1 = output) and `pad_out` equals the output data bit.
- R4: Function codes 01, 10 and 11 connect the pin to alternate pair 0, 1 and 2 (`alt_out`/`alt_oe` bit k*16+pin) whatever the direction bit holds.
- R5: `pad_pull_en` follows the pull-enable bit. `pad_pull_up` is 1 only when pull is enabled and the output data bit is 1; otherwise the pull, if enabled, pulls down.
- R6: When the edge-select bit is 0, a rising pin edge sets that pin's flag; when it is 1, a falling edge sets it. The flag is visible on the third clock edge after the pad changes. An edge of the other polarity leaves the flag unchanged.
- R7: Flags stay set until they are cleared. A write to the flag byte (0x1C/0x1D) loads it exactly as written, so a written 1 sets a flag and a written 0 clears it.
- R8: `irq[b]` is the OR over bank b of (flag AND enable), with the enable bytes at 0x1A/0x1B.
- R9: A read at 0x0E (bank A) or 0x1E (bank B) returns 0 when no flag of that bank is set, or else 2*(n+1) for the lowest set flag n, and it clears that flag. The high bytes 0x0F and 0x1F read 0 and clear nothing.
- R10: A 1 written to a bit of the select-flip byte (0x16/0x17) inverts both SEL0 (0x0A/0x0B) and SEL1 (0x0C/0x0D) of that pin. Reads of that byte return 0.
- R11: When an edge and a software clear reach the same flag on the same clock edge, the flag ends up set.
- R12: The drive-strength byte (0x08/0x09) reads back as written and appears on `pad_drive`. Offsets 0x10 to 0x15 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte address inside the window |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_rd | input | 1 | Read strobe; a vector read clears one flag at the edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle `bus_rd` is high |
| pad_in | input | 16 | Pad levels; bank A is bits 7:0 |
| pad_out | output | 16 | Value to drive on each pad |
| pad_oe | output | 16 | Output enable per pad |
| pad_pull_en | output | 16 | Pull resistor enable per pad |
| pad_pull_up | output | 16 | 1 = pull up, 0 = pull down |
| pad_drive | output | 16 | Drive-strength bits per pad |
| alt_out | input | 48 | Alternate-function output values, pair k at bits k*16+15:k*16 |
| alt_oe | input | 48 | Alternate-function output enables, same layout |
| irq | output | 2 | Interrupt line per bank |

## Verification
A flag register that gains or loses a bit shows up at the ports in two places. `irq` is combinational from the flags, so it changes on the same edge, and the next vector read returns a code that points at the wrong pin. A corrupted SEL or direction bit changes `pad_oe` and `pad_out` in the cycle after the write. The synchronizer depth can only be seen in timing, so the edge tests sample the interrupt line on the second and third edges after the pad changes, and a chain that is one flop short or one flop long shows up within a cycle.

// File: rtl/dual_gpio_pkg.sv
package dual_gpio_pkg;
    localparam int PORTS  = 2;
    localparam int PINS   = 8;
    localparam int NPIN   = PORTS * PINS;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int ALT_N  = 3;

    typedef logic [PORTS-1:0][PINS-1:0] bank_t;

    typedef struct packed {
        bank_t dout;
        bank_t dir;
        bank_t pull;
        bank_t drv;
        bank_t sel0;
        bank_t sel1;
        bank_t ies;
        bank_t ie;
        bank_t ifg;
    } gpio_regs_t;

    // register slot = byte address / 2; address bit 0 picks the bank
    typedef enum logic [3:0] {
        RS_LEVEL = 4'd0,
        RS_OUT   = 4'd1,
        RS_DIR   = 4'd2,
        RS_PULL  = 4'd3,
        RS_DRV   = 4'd4,
        RS_SEL0  = 4'd5,
        RS_SEL1  = 4'd6,
        RS_VECA  = 4'd7,
        RS_FLIP  = 4'd11,
        RS_EDGE  = 4'd12,
        RS_IEN   = 4'd13,
        RS_FLAG  = 4'd14,
        RS_VECB  = 4'd15
    } reg_slot_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    logic [STAGES-1:0][W-1:0] stg_q;
    logic [W-1:0]             prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q  <= '0;
            prev_q <= '0;
        end else begin
            stg_q[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
            prev_q <= stg_q[STAGES-1];
        end
    end

    assign lvl_o  = stg_q[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_vec_enc.sv
module gpio_vec_enc #(
    parameter int W  = 8,
    parameter int CW = 8
) (
    input  logic [W-1:0]  flags_i,
    output logic [CW-1:0] code_o,
    output logic [W-1:0]  pick_o
);
    always_comb begin
        code_o = '0;
        pick_o = '0;
        // scan downward so the lowest set flag is the last one to overwrite
        for (int i = W - 1; i >= 0; i--) begin
            if (flags_i[i]) begin
                code_o    = CW'(2 * (i + 1));
                pick_o    = '0;
                pick_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int NPIN  = 16,
    parameter int ALT_N = 3
) (
    input  logic [NPIN-1:0]       dout_i,
    input  logic [NPIN-1:0]       dir_i,
    input  logic [NPIN-1:0]       pull_i,
    input  logic [NPIN-1:0]       sel0_i,
    input  logic [NPIN-1:0]       sel1_i,
    input  logic [ALT_N*NPIN-1:0] alt_out_i,
    input  logic [ALT_N*NPIN-1:0] alt_oe_i,
    output logic [NPIN-1:0]       pad_out_o,
    output logic [NPIN-1:0]       pad_oe_o,
    output logic [NPIN-1:0]       pull_en_o,
    output logic [NPIN-1:0]       pull_up_o
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic [1:0] fsel;
        assign fsel = {sel1_i[i], sel0_i[i]};

        always_comb begin
            if (fsel == 2'b00) begin
                pad_out_o[i] = dout_i[i];
                pad_oe_o[i]  = dir_i[i];
            end else begin
                pad_out_o[i] = alt_out_i[(int'(fsel) - 1) * NPIN + i];
                pad_oe_o[i]  = alt_oe_i[(int'(fsel) - 1) * NPIN + i];
            end
        end

        assign pull_en_o[i] = pull_i[i];
        assign pull_up_o[i] = pull_i[i] & dout_i[i];
    end
endmodule

// File: rtl/dual_gpio_port.sv
module dual_gpio_port
    import dual_gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NPIN-1:0]       pad_in,
    output logic [NPIN-1:0]       pad_out,
    output logic [NPIN-1:0]       pad_oe,
    output logic [NPIN-1:0]       pad_pull_en,
    output logic [NPIN-1:0]       pad_pull_up,
    output logic [NPIN-1:0]       pad_drive,
    input  logic [ALT_N*NPIN-1:0] alt_out,
    input  logic [ALT_N*NPIN-1:0] alt_oe,
    output logic [PORTS-1:0]      irq
);
    gpio_regs_t st_d, st_q;

    logic [NPIN-1:0] lvl_flat, prev_flat;
    bank_t           lvl, lvl_prev, hit, vec_pick, clr;
    logic [PORTS-1:0][DATA_W-1:0] vec_code;

    reg_slot_e slot;
    logic      side;

    assign slot = reg_slot_e'(bus_addr[ADDR_W-1:1]);
    assign side = bus_addr[0];

    gpio_in_sync #(
        .W      (NPIN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pad_in),
        .lvl_o  (lvl_flat),
        .prev_o (prev_flat)
    );

    assign lvl      = lvl_flat;
    assign lvl_prev = prev_flat;
    assign hit      = (lvl & ~lvl_prev & ~st_q.ies) | (~lvl & lvl_prev & st_q.ies);

    for (genvar p = 0; p < PORTS; p++) begin : g_bank
        gpio_vec_enc #(
            .W  (PINS),
            .CW (DATA_W)
        ) u_vec (
            .flags_i (st_q.ifg[p]),
            .code_o  (vec_code[p]),
            .pick_o  (vec_pick[p])
        );
        assign irq[p] = |(st_q.ifg[p] & st_q.ie[p]);
    end

    // next-state
    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (bus_rd && !side) begin
            if (slot == RS_VECA) clr[0] = vec_pick[0];
            if (slot == RS_VECB) clr[1] = vec_pick[1];
        end
        if (bus_wr) begin
            case (slot)
                RS_OUT:  st_d.dout[side] = bus_wdata;
                RS_DIR:  st_d.dir[side]  = bus_wdata;
                RS_PULL: st_d.pull[side] = bus_wdata;
                RS_DRV:  st_d.drv[side]  = bus_wdata;
                RS_SEL0: st_d.sel0[side] = bus_wdata;
                RS_SEL1: st_d.sel1[side] = bus_wdata;
                RS_FLIP: begin
                    st_d.sel0[side] = st_q.sel0[side] ^ bus_wdata;
                    st_d.sel1[side] = st_q.sel1[side] ^ bus_wdata;
                end
                RS_EDGE: st_d.ies[side]  = bus_wdata;
                RS_IEN:  st_d.ie[side]   = bus_wdata;
                RS_FLAG: st_d.ifg[side]  = bus_wdata;
                default: ;
            endcase
        end
        // hardware edges are merged last so they beat any clear
        st_d.ifg = (st_d.ifg & ~clr) | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (slot)
                RS_LEVEL: bus_rdata = lvl[side];
                RS_OUT:   bus_rdata = st_q.dout[side];
                RS_DIR:   bus_rdata = st_q.dir[side];
                RS_PULL:  bus_rdata = st_q.pull[side];
                RS_DRV:   bus_rdata = st_q.drv[side];
                RS_SEL0:  bus_rdata = st_q.sel0[side];
                RS_SEL1:  bus_rdata = st_q.sel1[side];
                RS_VECA:  bus_rdata = side ? '0 : vec_code[0];
                RS_EDGE:  bus_rdata = st_q.ies[side];
                RS_IEN:   bus_rdata = st_q.ie[side];
                RS_FLAG:  bus_rdata = st_q.ifg[side];
                RS_VECB:  bus_rdata = side ? '0 : vec_code[1];
                default:  bus_rdata = '0;
            endcase
        end
    end

    gpio_pad_mux #(
        .NPIN  (NPIN),
        .ALT_N (ALT_N)
    ) u_pad (
        .dout_i    (st_q.dout),
        .dir_i     (st_q.dir),
        .pull_i    (st_q.pull),
        .sel0_i    (st_q.sel0),
        .sel1_i    (st_q.sel1),
        .alt_out_i (alt_out),
        .alt_oe_i  (alt_oe),
        .pad_out_o (pad_out),
        .pad_oe_o  (pad_oe),
        .pull_en_o (pad_pull_en),
        .pull_up_o (pad_pull_up)
    );

    assign pad_drive = st_q.drv;
endmodule

// File: rtl/dual_gpio_chk.sv
module dual_gpio_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_wdata,
    input logic [15:0] ifg,
    input logic [15:0] ies,
    input logic [15:0] ie,
    input logic [15:0] lvl,
    input logic [15:0] prev,
    input logic [15:0] sel0,
    input logic [15:0] sel1,
    input logic [15:0] dir,
    input logic [15:0] pad_oe,
    input logic [1:0]  irq
);
    logic [15:0] edge_seen, gpio_mode, flip_mask;
    logic        flag_wr, vec_rd, flip_wr;

    assign edge_seen = (lvl & ~prev & ~ies) | (~lvl & prev & ies);
    assign gpio_mode = ~(sel0 | sel1);
    assign flag_wr   = bus_wr && (bus_addr[4:1] == 4'd14);
    assign vec_rd    = bus_rd && ((bus_addr == 5'h0E) || (bus_addr == 5'h1E));
    assign flip_wr   = bus_wr && (bus_addr[4:1] == 4'd11);
    assign flip_mask = bus_addr[0] ? {bus_wdata, 8'h00} : {8'h00, bus_wdata};

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_wr && !vec_rd) |=> ((ifg & $past(ifg)) == $past(ifg))); // R7

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen != 16'h0) |=> ((ifg & $past(edge_seen)) == $past(edge_seen))); // R6

    AST_GPIO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & gpio_mode) == (dir & gpio_mode))); // R3

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~{|(ifg[15:8] & ie[15:8]), |(ifg[7:0] & ie[7:0])}) == 2'b00)); // R8

    AST_SEL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        flip_wr |=> ((sel0 == ($past(sel0) ^ $past(flip_mask))) &&
                     (sel1 == ($past(sel1) ^ $past(flip_mask))))); // R10
endmodule

bind dual_gpio_port dual_gpio_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .ifg       (st_q.ifg),
    .ies       (st_q.ies),
    .ie        (st_q.ie),
    .lvl       (lvl_flat),
    .prev      (prev_flat),
    .sel0      (st_q.sel0),
    .sel1      (st_q.sel1),
    .dir       (st_q.dir),
    .pad_oe    (pad_oe),
    .irq       (irq)
);

// File: tb/test_dual_gpio_port.sv
`timescale 1ns/1ps
module test_dual_gpio_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe, pad_pull_en, pad_pull_up, pad_drive;
    logic [47:0] alt_out = '0;
    logic [47:0] alt_oe = '0;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // bench copies of the configuration it writes
    logic [15:0] m_out, m_dir, m_pull, m_drv, m_sel0, m_sel1;

    always #2 clk = ~clk;

    dual_gpio_port i_dual_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
        .pad_drive(pad_drive), .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [7:0] exp_vec(input logic [7:0] f);
        for (int i = 0; i < 8; i++) if (f[i]) return 8'(2 * (i + 1));
        return 8'h00;
    endfunction

    function automatic logic [15:0] exp_oe();
        logic [15:0] r;
        for (int i = 0; i < 16; i++) begin
            case ({m_sel1[i], m_sel0[i]})
                2'b00:   r[i] = m_dir[i];
                2'b01:   r[i] = alt_oe[i];
                2'b10:   r[i] = alt_oe[16 + i];
                default: r[i] = alt_oe[32 + i];
            endcase
        end
        return r;
    endfunction

    function automatic logic [15:0] exp_out();
        logic [15:0] r;
        for (int i = 0; i < 16; i++) begin
            case ({m_sel1[i], m_sel0[i]})
                2'b00:   r[i] = m_out[i];
                2'b01:   r[i] = alt_out[i];
                2'b10:   r[i] = alt_out[16 + i];
                default: r[i] = alt_out[32 + i];
            endcase
        end
        return r;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 pad_oe", pad_oe, 16'h0);
        chk("R1 irq", irq, 2'b00);
        chk("R1 pull", {pad_pull_en, pad_pull_up}, 32'h0);
        chk("R1 drive", pad_drive, 16'h0);
        rd(5'h04, d); chk("R1 dir reads 0", d, 8'h00);
        rd(5'h1C, d); chk("R1 flag reads 0", d, 8'h00);

        // R2: level register and its latency
        @(negedge clk); pad_in = 16'hA55A;
        @(negedge clk);
        bus_addr = 5'h00; bus_rd = 1'b1;
        #1 chk("R2 level not yet visible after one edge", bus_rdata, 8'h00);
        @(negedge clk);
        #1 chk("R2 level bank A after two edges", bus_rdata, 8'h5A);
        bus_rd = 1'b0;
        rd(5'h01, d); chk("R2 level bank B", d, 8'hA5);
        wr(5'h00, 8'hFF);
        rd(5'h00, d); chk("R2 write to level ignored", d, 8'h5A);
        @(negedge clk); pad_in = 16'h0000;
        repeat (4) @(negedge clk);
        wr(5'h1C, 8'h00); wr(5'h1D, 8'h00);
        rd(5'h1C, d); chk("R7 flags cleared by write", d, 8'h00);

        // R3 R4 R5 R12: random configurations
        for (int it = 0; it < 40; it++) begin
            m_out  = 16'($urandom); m_dir  = 16'($urandom);
            m_pull = 16'($urandom); m_drv  = 16'($urandom);
            m_sel0 = (it < 10) ? 16'h0 : 16'($urandom);
            m_sel1 = (it < 10) ? 16'h0 : 16'($urandom);
            alt_out = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            alt_oe  = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            for (int b = 0; b < 2; b++) begin
                wr(5'h02 + 5'(b), m_out[b*8 +: 8]);
                wr(5'h04 + 5'(b), m_dir[b*8 +: 8]);
                wr(5'h06 + 5'(b), m_pull[b*8 +: 8]);
                wr(5'h08 + 5'(b), m_drv[b*8 +: 8]);
                wr(5'h0A + 5'(b), m_sel0[b*8 +: 8]);
                wr(5'h0C + 5'(b), m_sel1[b*8 +: 8]);
            end
            chk("R3 R4 pad_oe", pad_oe, exp_oe());
            chk("R3 R4 pad_out", pad_out, exp_out());
            chk("R5 pull enable", pad_pull_en, m_pull);
            chk("R5 pull up", pad_pull_up, m_pull & m_out);
            chk("R12 pad_drive", pad_drive, m_drv);
        end
        rd(5'h09, d); chk("R12 drive readback", d, m_drv[15:8]);

        // R12: reserved window
        wr(5'h10, 8'hFF); wr(5'h15, 8'h5A);
        rd(5'h10, d); chk("R12 reserved 0x10 reads 0", d, 8'h00);
        rd(5'h15, d); chk("R12 reserved 0x15 reads 0", d, 8'h00);

        // R10: select flip
        wr(5'h0A, 8'h0F); wr(5'h0C, 8'h33);
        wr(5'h16, 8'hFF);
        rd(5'h0A, d); chk("R10 sel0 flipped", d, 8'hF0);
        rd(5'h0C, d); chk("R10 sel1 flipped", d, 8'hCC);
        wr(5'h17, 8'h81);
        rd(5'h0B, d); chk("R10 bank B sel0 flipped", d, m_sel0[15:8] ^ 8'h81);
        rd(5'h16, d); chk("R10 flip reads 0", d, 8'h00);
        for (int a = 2; a < 14; a++) wr(5'(a), 8'h00);
        m_out = '0; m_dir = '0; m_pull = '0; m_drv = '0; m_sel0 = '0; m_sel1 = '0;
        alt_out = '0; alt_oe = '0;

        // R6: rising edge with timing
        wr(5'h1A, 8'h08);
        @(negedge clk); pad_in[3] = 1'b1;
        @(negedge clk);
        @(negedge clk); chk("R6 no flag two edges after rise", irq, 2'b00);
        @(negedge clk); chk("R6 rising sets flag on third edge", irq, 2'b01);
        wr(5'h1C, 8'h00);
        wr(5'h18, 8'h08);
        @(negedge clk); pad_in[3] = 1'b0;
        repeat (4) @(negedge clk);
        rd(5'h1C, d); chk("R6 falling sets flag when edge bit is 1", d, 8'h08);
        wr(5'h1C, 8'h00);
        @(negedge clk); pad_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        rd(5'h1C, d); chk("R6 rising ignored when edge bit is 1", d, 8'h00);

        // R7 R8: sticky flags, software writes, gating
        wr(5'h1C, 8'h81);
        repeat (10) @(negedge clk);
        rd(5'h1C, d); chk("R7 written flags stay set", d, 8'h81);
        chk("R8 irq masked when enable clear", irq, 2'b00);
        wr(5'h1A, 8'h01);
        chk("R8 irq bank A on enabled flag", irq, 2'b01);
        wr(5'h1D, 8'h24);
        chk("R8 bank B stays low without enable", irq[1], 1'b0);
        wr(5'h1B, 8'h04);
        chk("R8 bank B on enabled flag", irq, 2'b11);

        // R9: vectors
        rd(5'h0F, d); chk("R9 high byte reads 0", d, 8'h00);
        rd(5'h0E, d); chk("R9 lowest bank A", d, exp_vec(8'h81));
        rd(5'h0E, d); chk("R9 next bank A", d, exp_vec(8'h80));
        rd(5'h0E, d); chk("R9 empty bank A", d, 8'h00);
        chk("R9 irq A dropped after clearing", irq[0], 1'b0);
        rd(5'h1F, d); chk("R9 high byte bank B reads 0", d, 8'h00);
        rd(5'h1D, d); chk("R9 high byte read cleared nothing", d, 8'h24);
        rd(5'h1E, d); chk("R9 lowest bank B", d, exp_vec(8'h24));
        rd(5'h1E, d); chk("R9 next bank B", d, exp_vec(8'h20));
        rd(5'h1E, d); chk("R9 empty bank B", d, 8'h00);

        // R11: edge and clear on the same edge
        wr(5'h19, 8'h00);
        @(negedge clk); pad_in[13] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 5'h1D; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(5'h1D, d); chk("R11 edge beats clear", d, 8'h20);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule